// File: doc/BRIEF.md
# I2C Register-Mapped 8-Bit GPIO Expander

This block is an I2C target that gives a host controller access to an 8-bit general-purpose port through four byte registers. Those registers are an input view, an output latch, a polarity mask and a direction mask. The 7-bit target address combines a fixed 4-bit prefix with three strap inputs, so several expanders can share one bus. The block samples SCL and SDA through a two-stage synchronizer. It detects START and STOP conditions as SDA edges while SCL is high. It pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit.

In a write transaction, the first byte after the address is a command byte, and the block keeps it as a register pointer. Each further byte in the same transaction goes into the register that the pointer selects. The pointer does not advance. A read transaction returns the selected register. The pointer keeps its value across transactions until a new command byte arrives, so the host can poll the input port with short address-only reads. Pin outputs are driven by plain enable and data vectors. Pin inputs pass through a synchronizer and a per-bit inversion mask before they are read.

Top module: `gpx_expander`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {4'b0100, strap}, with bit 0 as the read flag (1 = read). An address that does not match is not acknowledged, and every later byte up to the next START is ignored.
- R2: In a write, the first byte after the address sets the pointer. Each later byte is stored in the register the pointer selects: 0x01 is the output latch, 0x02 the polarity mask and 0x03 the direction mask. With pointer 0x00 (the input view, read-only) or any value above 0x03, data bytes are acknowledged but change no register.
- R3: pin_oe[i] is the inverse of direction bit i. A direction bit of 1 makes the pin an input with its driver off.
- R4: pin_o always equals the output latch. The latch has no effect on a pin whose pin_oe is 0.
- R5: After reset the output latch is 0xFF, the polarity mask 0x00, the direction mask 0xFF (all pins inputs) and the pointer 0x00.
- R6: Reading pointer 0x01 returns the stored latch value, not the level on pin_i.
- R7: Reading pointer 0x00 returns the synchronized pin_i XOR the polarity mask. The value is captured when the byte is loaded for shifting, which is at the SCL falling edge that ends the preceding acknowledge bit.
- R8: The pointer keeps its value across transactions. A read with no command byte returns the register last selected. A pointer above 0x03 reads as 0x00.
- R9: Several data bytes in one write all go to the same register. In a read, the block sends the selected register again for each byte the controller acknowledges. On a NACK it stops driving SDA until the next START.
- R10: The block pulls SDA low during the ninth clock after a matched address and after every received byte. Its SDA drive changes only while SCL is low, except at a START or STOP.
- R11: A repeated START restarts address decoding at once, and a STOP returns the bus engine to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Port pin levels (asynchronous) |
| pin_o | output | 8 | Port output levels |
| pin_oe | output | 8 | Port output enables, 1 = driving |

## Verification
On every cycle, the assertions check three things: port outputs change only right after a received data byte, every stored byte coincides with an acknowledge, and SDA drive moves only while SCL is low. They also check that loading a read byte never disturbs the pointer. The bench scenarios are needed for the rest: address filtering against the straps, the register encodings, the polarity and capture timing of the input view, and pointer persistence across separate transactions. Multi-byte transfers that resample the pins between bytes also need a scenario.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] SEL_INPUT  = 8'h00;
  localparam logic [BYTE_W-1:0] SEL_LATCH  = 8'h01;
  localparam logic [BYTE_W-1:0] SEL_INVERT = 8'h02;
  localparam logic [BYTE_W-1:0] SEL_DIR    = 8'h03;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_RX,
    BUS_ACK,
    BUS_TX,
    BUS_TXACK
  } bus_state_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        q[i] <= RST_VAL[i];
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/gpx_bus_engine.sv
module gpx_bus_engine
  import gpx_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               sda_oe,
  output logic               wr_valid,
  output logic               wr_is_cmd,
  output logic [BYTE_W-1:0]  wr_byte,
  output logic               rd_load,
  output logic               bus_evt
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  bus_state_e        state;
  logic              scl_d, sda_d;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh;
  logic              addr_ph, rd_mode, cmd_next, nack_q;
  logic              start_det, stop_det, scl_rise, scl_fall;

  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
  assign scl_rise  = scl_s && !scl_d;
  assign scl_fall  = !scl_s && scl_d;
  assign bus_evt   = start_det || stop_det;
  assign sda_oe    = (state == BUS_ACK) || (state == BUS_TX && !sh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= BUS_IDLE;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      bitcnt    <= '0;
      sh        <= '0;
      addr_ph   <= 1'b0;
      rd_mode   <= 1'b0;
      cmd_next  <= 1'b0;
      nack_q    <= 1'b1;
      wr_valid  <= 1'b0;
      wr_is_cmd <= 1'b0;
      wr_byte   <= '0;
      rd_load   <= 1'b0;
    end else begin
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      wr_valid <= 1'b0;
      rd_load  <= 1'b0;
      if (start_det) begin
        state   <= BUS_RX;
        bitcnt  <= '0;
        addr_ph <= 1'b1;
      end else if (stop_det) begin
        state <= BUS_IDLE;
      end else begin
        case (state)
          BUS_RX: begin
            if (scl_rise) begin
              sh     <= {sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + CNT_W'(1);
            end else if (scl_fall && bitcnt == FULL) begin
              if (addr_ph) begin
                if (sh[BYTE_W-1:1] == {ADDR_HI, strap}) begin
                  state    <= BUS_ACK;
                  rd_mode  <= sh[0];
                  cmd_next <= !sh[0];
                  addr_ph  <= 1'b0;
                end else begin
                  state <= BUS_IDLE;
                end
              end else begin
                state     <= BUS_ACK;
                wr_valid  <= 1'b1;
                wr_is_cmd <= cmd_next;
                wr_byte   <= sh;
                cmd_next  <= 1'b0;
              end
            end
          end
          BUS_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                state   <= BUS_TX;
                sh      <= rd_data;
                rd_load <= 1'b1;
              end else begin
                state <= BUS_RX;
              end
            end
          end
          BUS_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                state <= BUS_TXACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + CNT_W'(1);
              end
            end
          end
          BUS_TXACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= BUS_IDLE;
              end else begin
                state   <= BUS_TX;
                bitcnt  <= '0;
                sh      <= rd_data;
                rd_load <= 1'b1;
              end
            end
          end
          default: state <= BUS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] pin_s,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr_q,
  output logic [BYTE_W-1:0] latch_q,
  output logic [BYTE_W-1:0] dir_q
);
  logic [BYTE_W-1:0] inv_q;
  logic [BYTE_W-1:0] in_view;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_view
    assign in_view[i] = pin_s[i] ^ inv_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= SEL_INPUT;
      latch_q <= '1;
      inv_q   <= '0;
      dir_q   <= '1;
    end else if (wr_valid) begin
      if (wr_is_cmd) begin
        ptr_q <= wr_byte;
      end else begin
        case (ptr_q)
          SEL_LATCH:  latch_q <= wr_byte;
          SEL_INVERT: inv_q   <= wr_byte;
          SEL_DIR:    dir_q   <= wr_byte;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ptr_q)
      SEL_INPUT:  rd_data = in_view;
      SEL_LATCH:  rd_data = latch_q;
      SEL_INVERT: rd_data = inv_q;
      SEL_DIR:    rd_data = dir_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  pin_i,
  output logic [BYTE_W-1:0]  pin_o,
  output logic [BYTE_W-1:0]  pin_oe
);
  logic              scl_s, sda_s;
  logic [BYTE_W-1:0] pin_s, rd_data, ptr_q, latch_q, dir_q, wr_byte;
  logic              wr_valid, wr_is_cmd, rd_load, bus_evt;

  gpx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  gpx_sync #(.W(BYTE_W), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  gpx_bus_engine #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .strap(strap),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_is_cmd(wr_is_cmd),
    .wr_byte(wr_byte), .rd_load(rd_load), .bus_evt(bus_evt)
  );

  gpx_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_is_cmd(wr_is_cmd),
    .wr_byte(wr_byte), .pin_s(pin_s), .rd_data(rd_data), .ptr_q(ptr_q),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  assign pin_o  = latch_q;
  assign pin_oe = ~dir_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       bus_evt,
  input logic       wr_valid,
  input logic       rd_load,
  input logic [7:0] ptr_q,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe
);
  AST_OE_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_valid)); // R3

  AST_LATCH_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> $past(wr_valid)); // R4

  AST_ACK_WITH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sda_oe); // R10

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(bus_evt)) |-> !scl_s); // R10

  AST_PTR_HELD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_load) |-> $stable(ptr_q)); // R8
endmodule

bind gpx_expander gpx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .bus_evt(bus_evt),
  .wr_valid(wr_valid), .rd_load(rd_load), .ptr_q(ptr_q), .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/gpx_expander_test.sv
module gpx_expander_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b0100, STRAP};
  localparam int NVEC = 6;
  // {command, data written, expected read-back}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    24'h01A5A5, 24'h02FFFF, 24'h030000, 24'h020F0F, 24'h013C3C, 24'h03F0F0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] pin_i = 8'h00;
  logic sda_oe;
  logic [7:0] pin_o, pin_oe;
  logic sda_line;
  int n_chk = 0;
  int n_err = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_expander uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(input string rq, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      q(); sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0;
    end
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = !sda_line; scl_m = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; scl_m = 1'b0;
    end
    q(); sda_m = !give_ack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q();
  endtask

  task automatic write_reg(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(cmd, a1); put_byte(d, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(cmd, a1);
    bus_start(); put_byte({DEV, 1'b1}, a2); get_byte(1'b0, d); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_cur(output logic [7:0] d, output logic ok);
    bus_start(); put_byte({DEV, 1'b1}, ok); get_byte(1'b0, d); bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic ok, a0, a1;
    logic [7:0] d, d1, d2, d3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5 / R3: reset state at the ports
    check("R5 pin_o reset", pin_o, 8'hFF);
    check("R3 pin_oe reset", pin_oe, 8'h00);

    // R5 / R8 / R7: pointer starts at input view, polarity clear
    pin_i = 8'h5A;
    read_cur(d, ok);
    check("R1 ack", {7'd0, ok}, 8'h01);
    check("R5 default pointer reads pins", d, 8'h5A);

    // R2 / R10 / R11: table of register writes and read-backs
    for (int k = 0; k < NVEC; k++) begin
      write_reg(VEC[k][23:16], VEC[k][15:8], ok);
      check("R10 write acks", {7'd0, ok}, 8'h01);
      read_reg(VEC[k][23:16], d, ok);
      check("R11 repeated start acks", {7'd0, ok}, 8'h01);
      check("R2 read-back", d, VEC[k][7:0]);
    end

    // R3 / R4: pins follow direction and latch
    check("R3 pin_oe inverse of dir", pin_oe, 8'h0F);
    check("R4 pin_o is latch", pin_o, 8'h3C);

    // R6: latch read ignores pins
    pin_i = 8'hC3;
    read_reg(8'h01, d, ok);
    check("R6 latch not pin", d, 8'h3C);

    // R7: input view inverted by polarity mask 0x0F
    read_reg(8'h00, d, ok);
    check("R7 input xor polarity", d, 8'hCC);

    // R8: command-only write, then two bare reads
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(8'h02, a1); bus_stop();
    check("R10 cmd-only acks", {7'd0, a0 & a1}, 8'h01);
    read_cur(d, ok);
    check("R8 pointer persists 1", d, 8'h0F);
    read_cur(d, ok);
    check("R8 pointer persists 2", d, 8'h0F);

    // R2: writes to input view and unmapped pointer change nothing
    write_reg(8'h00, 8'h77, ok);
    check("R2 input-view write acked", {7'd0, ok}, 8'h01);
    write_reg(8'h07, 8'h12, ok);
    check("R2 unmapped write acked", {7'd0, ok}, 8'h01);
    check("R2 latch untouched", pin_o, 8'h3C);
    check("R2 dir untouched", pin_oe, 8'h0F);
    read_cur(d, ok);
    check("R8 unmapped reads zero", d, 8'h00);
    read_reg(8'h02, d, ok);
    check("R2 polarity untouched", d, 8'h0F);

    // R9: multi-byte write lands in one register
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(8'h01, a1);
    put_byte(8'hAA, ok); put_byte(8'h55, ok); bus_stop();
    check("R9 last byte wins", pin_o, 8'h55);

    // R9 / R7: multi-byte read resamples at each load
    pin_i = 8'h00;
    bus_start(); put_byte({DEV, 1'b0}, a0); put_byte(8'h00, a1);
    bus_start(); put_byte({DEV, 1'b1}, a0);
    get_byte(1'b1, d1);
    pin_i = 8'hFF;
    get_byte(1'b1, d2);
    get_byte(1'b0, d3);
    check("R9 release after nack", {7'd0, sda_line}, 8'h01);
    bus_stop();
    check("R9 byte1", d1, 8'h0F);
    check("R7 byte2 loaded before change", d2, 8'h0F);
    check("R7 byte3 resampled", d3, 8'hF0);

    // R1: wrong address ignored, including later bytes
    bus_start(); put_byte({4'b0100, 3'b100, 1'b0}, a0); put_byte(8'h01, a1);
    put_byte(8'h00, ok); bus_stop();
    check("R1 no ack wrong addr", {7'd0, a0}, 8'h00);
    check("R1 later byte no ack", {7'd0, a1}, 8'h00);
    check("R1 latch untouched", pin_o, 8'h55);

    finish_run();
  end
endmodule